// File: doc/BRIEF.md
# Single-Cycle Integer Core (15-Instruction Subset)

This block is a non-pipelined 32-bit processor that completes one instruction on every clock edge. It executes register-register operations (ADD, SUB, XOR, OR, AND), their immediate forms (ADDI, XORI, ORI, ANDI), one jump-and-link, two conditional branches (equal and not-equal), a word load, a word store, and a stop instruction encoded by the all-ones opcode. It has a 32-entry register file and two separate byte-wide memories, one for instructions and one for data. Each memory assembles a 32-bit word from four consecutive bytes, with the most significant byte at the lowest address.

A host fills both memories through a byte-wide load port while reset is held. The host then releases reset and waits for `halted`. The data memory and the instruction memory can be read back one byte at a time through the same port. Two counters run alongside execution: clocks spent running, and instructions completed. The host derives CPI from them.

Top module: `mini_rv_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, both counters and `halted` go to zero, and every register x1..x31 becomes zero.
- R2: The memories are big-endian. The word at byte address A is {mem[A], mem[A+1], mem[A+2], mem[A+3]}, with mem[A] in bits 31:24. Addresses wrap modulo the memory size.
- R3: Opcode 0110011 is register-register. funct7 0000000 with funct3 000, 100, 110 or 111 gives ADD, XOR, OR or AND. funct7 0100000 with funct3 000 gives SUB. The result is written to rd.
- R4: Opcode 0010011 with funct3 000, 100, 110 or 111 gives ADDI, XORI, ORI or ANDI. These use the sign-extended immediate in bits 31:20. Sums wrap modulo 2^32.
- R5: Opcode 1101111 writes PC+4 to rd and adds the sign-extended J-format offset {b31, b19:12, b20, b30:21, 0} to the PC.
- R6: Opcode 1100011 with funct3 000 branches when rs1 equals rs2. With funct3 001 it branches when they differ. The target is PC plus the B-format offset {b31, b7, b30:25, b11:8, 0}. Otherwise the PC advances by 4.
- R7: Opcode 0000011 with funct3 000 loads a word into rd. Opcode 0100011 with funct3 010 stores rs2 as a word. Both use the address rs1 plus the sign-extended immediate, which is bits 31:20 for loads and {b31:25, b11:7} for stores.
- R8: x0 reads as zero, and any write to it is dropped.
- R9: Opcode 1111111 sets `halted`. From then on, the PC, the registers and the data memory stay unchanged until reset.
- R10: `cycle_count` and `retired_count` each go up by one on every edge out of reset before the halt, and that includes the halt instruction's own edge. Both hold once halted.
- R11: Any encoding outside R3–R9 changes no register or memory. It advances the PC by 4 and counts as retired.
- R12: Load-port writes (`ld_we`) take effect only while `rst` is high. `peek_data` shows the byte at `ld_addr` one clock later. It reads the instruction memory when `ld_imem` is 1 and the data memory when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Host byte write strobe (honoured only in reset) |
| ld_imem | input | 1 | Host target: 1 instruction memory, 0 data memory |
| ld_addr | input | LD_AW | Host byte address for write and peek |
| ld_wdata | input | 8 | Host write byte |
| peek_data | output | 8 | Registered byte read at ld_addr |
| pc_out | output | 32 | Current program counter |
| halted | output | 1 | Set once the stop instruction executes |
| cycle_count | output | CW | Clocks spent running since reset |
| retired_count | output | CW | Instructions completed since reset |

## Verification
The bench uses the default sizes: 1 KiB for each memory and 32-bit counters. With those sizes, one program image fits a random body, a store area and two full register dumps. The bench can also sweep the entire data memory through the peek port after each run, so every byte a stray store could touch is compared. The 32-bit counters cannot wrap within any test program, so cycle and retire totals are compared exactly against a step count from a bench instruction model.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  localparam int XLEN = 32;

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_BR   = 7'b1100011;
  localparam logic [6:0] OPC_LD   = 7'b0000011;
  localparam logic [6:0] OPC_ST   = 7'b0100011;
  localparam logic [6:0] OPC_STOP = 7'b1111111;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_XOR,
    ALU_OR,
    ALU_AND
  } alu_op_e;

  typedef struct packed {
    alu_op_e           alu;
    logic              use_imm;
    logic              wr_rd;
    logic              ld;
    logic              st;
    logic              jal;
    logic              br;
    logic              br_ne;
    logic              stop;
    logic [XLEN-1:0]   imm;
    logic [4:0]        rd;
    logic [4:0]        rs1;
    logic [4:0]        rs2;
  } dec_t;

endpackage

// File: rtl/rvs_decode.sv
module rvs_decode
  import rvs_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output dec_t            dec
);

  logic [2:0]      f3;
  logic [6:0]      f7;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_j;
  logic            lop_ok;
  alu_op_e         lop;

  assign f3 = insn[14:12];
  assign f7 = insn[31:25];

  assign imm_i = {{20{insn[31]}}, insn[31:20]};
  assign imm_s = {{20{insn[31]}}, insn[31:25], insn[11:7]};
  assign imm_b = {{19{insn[31]}}, insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
  assign imm_j = {{11{insn[31]}}, insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};

  // funct3 -> logic/add operation shared by both ALU opcode groups
  always_comb begin
    lop_ok = 1'b1;
    lop    = ALU_ADD;
    case (f3)
      3'b000:  lop = ALU_ADD;
      3'b100:  lop = ALU_XOR;
      3'b110:  lop = ALU_OR;
      3'b111:  lop = ALU_AND;
      default: lop_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec     = '0;
    dec.alu = ALU_ADD;
    dec.rd  = insn[11:7];
    dec.rs1 = insn[19:15];
    dec.rs2 = insn[24:20];
    case (insn[6:0])
      OPC_REG: begin
        if (f7 == 7'b0000000 && lop_ok) begin
          dec.alu   = lop;
          dec.wr_rd = 1'b1;
        end else if (f7 == 7'b0100000 && f3 == 3'b000) begin
          dec.alu   = ALU_SUB;
          dec.wr_rd = 1'b1;
        end
      end
      OPC_IMM: begin
        if (lop_ok) begin
          dec.alu     = lop;
          dec.use_imm = 1'b1;
          dec.imm     = imm_i;
          dec.wr_rd   = 1'b1;
        end
      end
      OPC_LD: begin
        if (f3 == 3'b000) begin
          dec.ld      = 1'b1;
          dec.use_imm = 1'b1;
          dec.imm     = imm_i;
          dec.wr_rd   = 1'b1;
        end
      end
      OPC_ST: begin
        if (f3 == 3'b010) begin
          dec.st      = 1'b1;
          dec.use_imm = 1'b1;
          dec.imm     = imm_s;
        end
      end
      OPC_BR: begin
        if (f3[2:1] == 2'b00) begin
          dec.br    = 1'b1;
          dec.br_ne = f3[0];
          dec.imm   = imm_b;
        end
      end
      OPC_JAL: begin
        dec.jal   = 1'b1;
        dec.wr_rd = 1'b1;
        dec.imm   = imm_j;
      end
      OPC_STOP: dec.stop = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/rvs_alu.sv
module rvs_alu
  import rvs_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_XOR: y = a ^ b;
      ALU_OR:  y = a | b;
      ALU_AND: y = a & b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/rvs_regfile.sv
module rvs_regfile #(
  parameter int NREG = 32,
  parameter int XW   = 32,
  parameter int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [XW-1:0]   wd,
  input  logic [RA_W-1:0] ra1,
  output logic [XW-1:0]   rd1,
  input  logic [RA_W-1:0] ra2,
  output logic [XW-1:0]   rd2
);

  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rvs_bytemem.sv
module rvs_bytemem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] waddr,
  output logic [31:0]   wrdata,
  input  logic          wwe,
  input  logic [31:0]   wwdata,
  input  logic          bwe,
  input  logic [AW-1:0] baddr,
  input  logic [7:0]    bwdata,
  input  logic [AW-1:0] paddr,
  output logic [7:0]    pdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // big-endian word read: lane 0 is the lowest address and the top byte
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [AW-1:0] lane_addr;
    assign lane_addr = waddr + AW'(g);
    assign wrdata[31-8*g -: 8] = mem[lane_addr];
  end

  always_ff @(posedge clk) begin
    if (bwe) begin
      mem[baddr] <= bwdata;
    end else if (wwe) begin
      for (int i = 0; i < 4; i++) mem[waddr + AW'(i)] <= wwdata[31-8*i -: 8];
    end
  end

  always_ff @(posedge clk) pdata <= mem[paddr];

endmodule

// File: rtl/mini_rv_core.sv
module mini_rv_core
  import rvs_pkg::*;
#(
  parameter int IMEM_AW = 10,
  parameter int DMEM_AW = 10,
  parameter int CW      = 32,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic             ld_imem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [7:0]       ld_wdata,
  output logic [7:0]       peek_data,
  output logic [31:0]      pc_out,
  output logic             halted,
  output logic [CW-1:0]    cycle_count,
  output logic [CW-1:0]    retired_count
);

  logic [XLEN-1:0] pc_q, pc_nxt, pc_plus4, pc_target;
  logic [XLEN-1:0] insn, rs1_v, rs2_v, alu_b, alu_y, dmem_rdata, wb_data;
  logic [7:0]      ipeek, dpeek;
  logic            halted_q, peek_sel_q, active, redirect, taken, rf_we;
  dec_t            dec;

  assign active = !rst && !halted_q;

  rvs_bytemem #(.AW(IMEM_AW)) u_imem (
    .clk    (clk),
    .waddr  (pc_q[IMEM_AW-1:0]),
    .wrdata (insn),
    .wwe    (1'b0),
    .wwdata ('0),
    .bwe    (rst && ld_we && ld_imem),
    .baddr  (ld_addr[IMEM_AW-1:0]),
    .bwdata (ld_wdata),
    .paddr  (ld_addr[IMEM_AW-1:0]),
    .pdata  (ipeek)
  );

  rvs_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  rvs_regfile #(.NREG(32), .XW(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (dec.rd),
    .wd  (wb_data),
    .ra1 (dec.rs1),
    .rd1 (rs1_v),
    .ra2 (dec.rs2),
    .rd2 (rs2_v)
  );

  assign alu_b = dec.use_imm ? dec.imm : rs2_v;

  rvs_alu u_alu (
    .a  (rs1_v),
    .b  (alu_b),
    .op (dec.alu),
    .y  (alu_y)
  );

  rvs_bytemem #(.AW(DMEM_AW)) u_dmem (
    .clk    (clk),
    .waddr  (alu_y[DMEM_AW-1:0]),
    .wrdata (dmem_rdata),
    .wwe    (active && dec.st),
    .wwdata (rs2_v),
    .bwe    (rst && ld_we && !ld_imem),
    .baddr  (ld_addr[DMEM_AW-1:0]),
    .bwdata (ld_wdata),
    .paddr  (ld_addr[DMEM_AW-1:0]),
    .pdata  (dpeek)
  );

  // next-PC selection
  assign pc_plus4  = pc_q + 32'd4;
  assign pc_target = pc_q + dec.imm;
  assign taken     = dec.br && ((rs1_v == rs2_v) ^ dec.br_ne);
  assign redirect  = dec.jal || taken;
  assign pc_nxt    = dec.stop ? pc_q : (redirect ? pc_target : pc_plus4);

  assign wb_data = dec.ld ? dmem_rdata : (dec.jal ? pc_plus4 : alu_y);
  assign rf_we   = active && dec.wr_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q          <= '0;
      halted_q      <= 1'b0;
      cycle_count   <= '0;
      retired_count <= '0;
    end else if (!halted_q) begin
      pc_q          <= pc_nxt;
      halted_q      <= dec.stop;
      cycle_count   <= cycle_count + 1'b1;
      retired_count <= retired_count + 1'b1;
    end
  end

  always_ff @(posedge clk) peek_sel_q <= ld_imem;

  assign peek_data = peek_sel_q ? ipeek : dpeek;
  assign pc_out    = pc_q;
  assign halted    = halted_q;

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic [31:0]   pc_out,
  input logic [CW-1:0] cycle_count,
  input logic [CW-1:0] retired_count,
  input logic          redirect,
  input logic          is_stop
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1)
      AST_RESET_STATE: assert (pc_out == '0 && !halted && cycle_count == '0 && retired_count == '0); // R1
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R9
  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(pc_out)); // R9
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst) (!halted && is_stop) |=> (halted && pc_out == $past(pc_out))); // R9
  AST_COUNT_FREEZE: assert property (@(posedge clk) disable iff (rst) halted |=> ($stable(cycle_count) && $stable(retired_count))); // R10
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst) !halted |=> retired_count == $past(retired_count) + 1'b1); // R10
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst) (!halted && !redirect && !is_stop) |=> pc_out == $past(pc_out) + 32'd4); // R11

endmodule

bind mini_rv_core rvs_checker #(.CW(CW)) i_rvs_checker (
  .clk           (clk),
  .rst           (rst),
  .halted        (halted),
  .pc_out        (pc_out),
  .cycle_count   (cycle_count),
  .retired_count (retired_count),
  .redirect      (redirect),
  .is_stop       (dec.stop)
);

// File: tb/test_mini_rv_core.sv
module test_mini_rv_core;

  localparam int MSZ = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_imem = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [7:0]  ld_wdata = '0;
  logic [7:0]  peek_data;
  logic [31:0] pc_out;
  logic        halted;
  logic [31:0] cycle_count, retired_count;

  int tests = 0;
  int fails = 0;
  int wd_cyc = 0;

  always #5 clk = ~clk;

  mini_rv_core i_mini_rv_core (
    .clk, .rst, .ld_we, .ld_imem, .ld_addr, .ld_wdata,
    .peek_data, .pc_out, .halted, .cycle_count, .retired_count
  );

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog (R9 halt never reached): got %0d cycles expected fewer", wd_cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- bench reference model ----------------
  logic [7:0]  m_imem [MSZ];
  logic [7:0]  m_dmem [MSZ];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;
  int          m_steps;
  int          ip;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word(input logic [31:0] a, input bit instr);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      w = (w << 8) | 32'(instr ? m_imem[(a + k) % MSZ] : m_dmem[(a + k) % MSZ]);
    return w;
  endfunction

  task automatic put(input logic [31:0] w);
    for (int k = 0; k < 4; k++) m_imem[4*ip + k] = w[31-8*k -: 8];
    ip++;
  endtask

  function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1, input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input int imm, input int rs1, input logic [2:0] f3, input int rd, input logic [6:0] opc);
    logic [11:0] v = 12'(imm);
    return {v, 5'(rs1), f3, 5'(rd), opc};
  endfunction
  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
    logic [11:0] v = 12'(imm);
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int off, input int rs2, input int rs1, input bit ne);
    logic [12:0] v = 13'(off);
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), 2'b00, ne, v[4:1], v[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(input int off, input int rd);
    logic [20:0] v = 21'(off);
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction

  task automatic m_run();
    bit stop = 0;
    m_pc = 0;
    m_steps = 0;
    for (int r = 0; r < 32; r++) m_reg[r] = '0;
    while (!stop && m_steps < 20000) begin
      logic [31:0] w, a, b, res, nxt, ii, si, bi, ji;
      logic [2:0]  f3;
      bit          wr;
      w   = m_word(m_pc, 1'b1);
      f3  = w[14:12];
      a   = m_reg[w[19:15]];
      b   = m_reg[w[24:20]];
      ii  = 32'($signed(w[31:20]));
      si  = 32'($signed({w[31:25], w[11:7]}));
      bi  = 32'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0}));
      ji  = 32'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0}));
      nxt = m_pc + 4;
      wr  = 0;
      res = '0;
      case (w[6:0])
        7'b1111111: begin stop = 1; nxt = m_pc; end
        7'b0110011, 7'b0010011: begin
          logic [31:0] op2 = (w[6:0] == 7'b0110011) ? b : ii;
          bit regform = (w[6:0] == 7'b0110011);
          if (regform && w[31:25] == 7'b0100000 && f3 == 3'b000) begin res = a - op2; wr = 1; end
          else if (!regform || w[31:25] == 7'b0000000) begin
            wr = 1;
            if (f3 == 3'b000) res = a + op2;
            else if (f3 == 3'b100) res = a ^ op2;
            else if (f3 == 3'b110) res = a | op2;
            else if (f3 == 3'b111) res = a & op2;
            else wr = 0;
          end
        end
        7'b0000011: if (f3 == 3'b000) begin res = m_word(a + ii, 1'b0); wr = 1; end
        7'b0100011: if (f3 == 3'b010) begin
          for (int k = 0; k < 4; k++) m_dmem[(a + si + k) % MSZ] = 8'(b >> (24 - 8*k));
        end
        7'b1100011: begin
          if ((f3 == 3'b000 && a == b) || (f3 == 3'b001 && a != b)) nxt = m_pc + bi;
        end
        7'b1101111: begin res = m_pc + 4; wr = 1; nxt = m_pc + ji; end
        default: ;
      endcase
      if (wr && w[11:7] != 0) m_reg[w[11:7]] = res;
      m_pc = nxt;
      m_steps++;
    end
  endtask

  // ---------------- DUT access ----------------
  task automatic peek(input bit imem, input int a, output logic [7:0] v);
    @(negedge clk);
    ld_imem = imem;
    ld_addr = 10'(a);
    @(negedge clk);
    v = peek_data;
  endtask

  task automatic peek_word(input int a, output logic [31:0] w);
    logic [7:0] v;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      peek(1'b0, a + k, v);
      w = {w[23:0], v};
    end
  endtask

  // loads both images in reset, runs, and checks the full image against the model
  task automatic run_and_check(input string name);
    int n = 0;
    int bad = 0;
    logic [7:0] v, v0;
    @(negedge clk);
    rst = 1'b1;
    for (int a = 0; a < 2*MSZ; a++) begin
      @(negedge clk);
      ld_we    = 1'b1;
      ld_imem  = (a < MSZ);
      ld_addr  = 10'(a % MSZ);
      ld_wdata = (a < MSZ) ? m_imem[a] : m_dmem[a - MSZ];
    end
    @(negedge clk);
    ld_we = 1'b0;
    chk("R1", {name, " pc in reset"}, pc_out, 32'h0);
    chk("R1", {name, " halted/counters in reset"}, {31'(cycle_count | retired_count), halted}, 32'h0);
    peek(1'b1, 4, v);
    chk("R12", {name, " imem preload byte 4"}, 32'(v), 32'(m_imem[4]));
    m_run();
    rst = 1'b0;
    do begin
      @(negedge clk);
      n++;
    end while (!halted && n < 30000);
    chk("R9", {name, " halted raised"}, 32'(halted), 32'h1);
    chk("R10", {name, " cycle count"}, cycle_count, 32'(m_steps));
    chk("R10", {name, " retired count"}, retired_count, 32'(m_steps));
    chk("R5 R6", {name, " final pc"}, pc_out, m_pc);
    repeat (12) @(negedge clk);
    chk("R9", {name, " pc frozen after halt"}, pc_out, m_pc);
    chk("R10", {name, " counters frozen"}, cycle_count ^ retired_count ^ 32'(m_steps), 32'(m_steps));
    // host write outside reset must be dropped
    peek(1'b0, 0, v0);
    @(negedge clk);
    ld_we = 1'b1; ld_imem = 1'b0; ld_addr = '0; ld_wdata = ~m_dmem[0];
    @(negedge clk);
    ld_we = 1'b0;
    peek(1'b0, 0, v);
    chk("R12", {name, " load port ignored outside reset"}, 32'(v), 32'(m_dmem[0]));
    for (int a = 0; a < MSZ; a++) begin
      peek(1'b0, a, v);
      if (v !== m_dmem[a]) begin
        if (bad == 0) $display("FAIL R2 R7 %s dmem[%0d]: got %h expected %h", name, a, v, m_dmem[a]);
        bad++;
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic clear_images();
    ip = 0;
    for (int a = 0; a < MSZ; a++) begin
      m_imem[a] = 8'h00;
      m_dmem[a] = 8'($urandom);
    end
  endtask

  initial begin
    logic [31:0] w;
    int jal_idx, seed;
    seed = $urandom(32'd6913);
    repeat (3) @(negedge clk);

    // ---- directed program A ----
    clear_images();
    m_dmem[512] = 8'h11; m_dmem[513] = 8'h22; m_dmem[514] = 8'h33; m_dmem[515] = 8'h44;
    for (int r = 1; r < 32; r++) put(e_s(768 + 4*r, r, 0));      // R1 dump of reset registers
    put(e_i(5, 0, 3'b000, 0, 7'b0010011));                        // x0 <- 5 (dropped)
    put(e_i(-1, 0, 3'b000, 1, 7'b0010011));                       // x1 = -1
    put(e_i(1, 1, 3'b000, 2, 7'b0010011));                        // x2 = wraps to 0
    put(e_i(512, 0, 3'b000, 3, 7'b0000011));                      // LW x3
    put(e_s(600, 3, 0));                                          // SW x3
    put(e_b(8, 0, 2, 1'b0));                                      // BEQ taken
    put(e_i(99, 0, 3'b000, 4, 7'b0010011));                       // skipped
    put(e_b(8, 0, 2, 1'b1));                                      // BNE not taken
    put(e_i(3, 0, 3'b000, 5, 7'b0010011));
    put(e_i(-1, 5, 3'b000, 5, 7'b0010011));                       // loop body
    put(e_b(-4, 0, 5, 1'b1));                                     // backward BNE
    jal_idx = ip;
    put(e_j(8, 6));
    put(e_i(77, 0, 3'b000, 7, 7'b0010011));                       // skipped
    put(e_s(604, 0, 0));
    put(e_i(12'h0F0, 1, 3'b100, 9, 7'b0010011));                  // XORI
    put(e_i(-256, 3, 3'b111, 10, 7'b0010011));                    // ANDI
    put(e_i(12'h7FF, 0, 3'b110, 11, 7'b0010011));                 // ORI
    put(e_r(7'b0000000, 1, 3, 3'b000, 12));                       // ADD
    put(e_r(7'b0100000, 3, 0, 3'b000, 13));                       // SUB
    put(e_r(7'b0000000, 1, 3, 3'b100, 14));                       // XOR
    put(e_r(7'b0000000, 10, 3, 3'b111, 15));                      // AND
    put(e_r(7'b0000000, 11, 9, 3'b110, 16));                      // OR
    for (int r = 1; r < 32; r++) put(e_s(896 + 4*(r - 1), r, 0));
    put(32'hFFFF_FFFF);
    run_and_check("progA");
    for (int r = 1; r < 32; r++) begin
      peek_word(768 + 4*r, w);
      if (r == 1 || r == 31) chk("R1", $sformatf("x%0d zero after reset", r), w, 32'h0);
    end
    peek_word(600, w);  chk("R2 R7", "big-endian LW/SW word", w, 32'h1122_3344);
    peek_word(604, w);  chk("R8", "x0 stays zero", w, 32'h0);
    peek_word(896, w);  chk("R4", "ADDI -1 sign extension", w, 32'hFFFF_FFFF);
    peek_word(900, w);  chk("R4", "ADDI overflow wraps", w, 32'h0);
    peek_word(908, w);  chk("R6", "BEQ taken skips", w, 32'h0);
    peek_word(912, w);  chk("R6", "BNE loop count", w, 32'h0);
    peek_word(916, w);  chk("R5", "JAL link", w, 32'(4*(jal_idx + 1)));
    peek_word(920, w);  chk("R5", "JAL skips", w, 32'h0);
    peek_word(928, w);  chk("R4", "XORI", w, 32'hFFFF_FF0F);
    peek_word(932, w);  chk("R4", "ANDI", w, 32'h1122_3300);
    peek_word(940, w);  chk("R3", "ADD", w, 32'h1122_3343);
    peek_word(944, w);  chk("R3", "SUB", w, 32'hEEDD_CCBC);
    peek_word(948, w);  chk("R3", "XOR", w, 32'hEEDD_CCBB);
    peek_word(956, w);  chk("R3", "OR", w, 32'hFFFF_FFFF);

    // ---- directed program B: unsupported encodings ----
    clear_images();
    put(e_i(7, 0, 3'b000, 1, 7'b0010011));
    put(e_r(7'b0000001, 0, 0, 3'b000, 1));                        // unsupported funct7
    put(e_i(1, 0, 3'b010, 1, 7'b0010011));                        // unsupported funct3
    put(32'h0000_000F);                                           // unsupported opcode
    put(e_i(1, 1, 3'b000, 1, 7'b0010011));
    put(e_s(700, 1, 0));
    put(32'h0000_007F);
    run_and_check("progB");
    peek_word(700, w);  chk("R11", "unsupported has no effect", w, 32'h8);
    chk("R11", "retired includes unsupported", retired_count, 32'd7);

    // ---- random programs ----
    for (int t = 0; t < 4; t++) begin
      clear_images();
      for (int r = 1; r < 32; r++) put(e_i(int'($urandom % 4096) - 2048, 0, 3'b000, r, 7'b0010011));
      for (int k = 0; k < 60; k++) begin
        int kind = $urandom % 8;
        int rd = $urandom % 32, ra = $urandom % 32, rb = $urandom % 32;
        logic [2:0] f3s [4] = '{3'b000, 3'b100, 3'b110, 3'b111};
        logic [2:0] f3 = f3s[$urandom % 4];
        case (kind)
          0: put(e_r(7'b0000000, rb, ra, f3, rd));
          1: put(e_r(7'b0100000, rb, ra, 3'b000, rd));
          2: put(e_i(int'($urandom % 4096) - 2048, ra, f3, rd, 7'b0010011));
          3: put(e_i(512 + 4*int'($urandom % 64), 0, 3'b000, rd, 7'b0000011));
          4: put(e_s(512 + 4*int'($urandom % 64), rb, 0));
          5: put(e_b(8, rb, ra, 1'($urandom)));
          6: put(e_j(8, rd));
          default: put($urandom & 32'hFFFF_FF0F | 32'h0000_0001);
        endcase
      end
      for (int r = 1; r < 32; r++) put(e_s(768 + 4*r, r, 0));
      put(32'hFFFF_FFFF);
      run_and_check($sformatf("rand%0d", t));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule